// File: doc/BRIEF.md
# Mains-Tick BCD Time-of-Day Counter

This block keeps the time of day as four packed-BCD fields: hours, minutes, seconds and tenths of a second. It gets its time base from an external tick pin. That pin carries pulses derived from the power line, either 50 Hz or 60 Hz. The block does not use the system clock as its time base. Bit 7 of a control byte tells the prescaler how many line ticks make up one tenth of a second, so one design serves both line standards. Software must set that bit to match the supply before it relies on the time.

The tick pin is asynchronous. It passes through a synchroniser and a rising-edge detector and then reaches a prescaler that counts to 6 or to 5. Each time the prescaler reaches its limit, a tenth step is sent into a BCD carry chain that runs across the four fields.

A write to the hours field stops the clock. A write to the tenths field starts it again. This lets software load a complete time with no rollover between the byte writes. A single register port is used for writes and a combinational port for reads.

Top module: `tod_clock`

## Requirements
- R1: After reset the fields read tenths 0x00, seconds 0x00, minutes 0x00, hours 0x12 and control 0x00. The clock is halted, so tick pulses leave every field unchanged until the tenths field is written.
- R2: The tick pin is sampled through two flops and a rising-edge detector. Each low-to-high transition counts exactly once, whether the high time is one system clock or many.
- R3: With control bit 7 clear (60 Hz mode), a running clock advances tenths by one for every 6 counted tick edges.
- R4: Writing the tenths field (address 0) starts a halted clock. The prescaler then begins from an empty count, so the first tenth step follows a full set of tick edges.
- R5: Writing the hours field (address 3) halts the clock and empties the prescaler. While halted, tick pulses change no field.
- R6: With control bit 7 set (50 Hz mode, written at address 4), a running clock advances tenths by one for every 5 counted tick edges.
- R7: Tenths wraps 9 to 0 and carries into seconds. Seconds and minutes count in BCD, so x9 rolls to the next ten. Each wraps 0x59 to 0x00 and carries into the next field.
- R8: Hours counts in BCD from 0x01 to 0x12. The value 0x09 rolls to 0x10, and 0x12 wraps to 0x01.
- R9: A write to a time field (addresses 0 to 3) takes effect on the next clock edge. Tenths keeps data bits 3:0, seconds and minutes keep bits 6:0, and hours keeps bits 4:0. A tenth step that falls in the same cycle as the write is discarded.
- R10: The read port returns tenths, seconds, minutes and hours at addresses 0 to 3. Address 4 returns the rate bit in bit 7 with the other bits zero. Addresses 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Asynchronous line-frequency tick pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 tenths, 1 seconds, 2 minutes, 3 hours, 4 control) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address, same map as writes |
| rd_data | output | 8 | Read data for rd_addr, combinational |

## Verification
The tick pin is driven in several ways while the clock is halted and while it runs:
- Regular pulses in both rate modes. These separate a divide-by-6 prescaler from a divide-by-5 one.
- Single-cycle pulses and long, stretched pulses. These show whether an edge is counted once, or is counted per level or per cycle.
- Short bursts after a halt and restart. These show whether the prescaler is emptied when the clock stops.

Preloaded times just before each rollover (x9, 59, 09 hours and 12:59:59.9) separate correct BCD carries from binary wrap-around.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 3;
    localparam int RATE_BIT = 7;

    typedef enum logic [ADDR_W-1:0] {
        FLD_TENTHS = 3'd0,
        FLD_SECS   = 3'd1,
        FLD_MINS   = 3'd2,
        FLD_HOURS  = 3'd3,
        FLD_CTRL   = 3'd4
    } tod_field_e;

    typedef struct packed {
        logic [BYTE_W-1:0] hours;
        logic [BYTE_W-1:0] mins;
        logic [BYTE_W-1:0] secs;
        logic [BYTE_W-1:0] tenths;
    } tod_time_t;

    typedef struct packed {
        logic              carry;
        logic [BYTE_W-1:0] value;
    } bcd_roll_t;

    localparam logic [BYTE_W-1:0] TENTHS_TOP  = 8'h09;
    localparam logic [BYTE_W-1:0] SIXTY_TOP   = 8'h59;
    localparam logic [BYTE_W-1:0] HOURS_TOP   = 8'h12;
    localparam logic [BYTE_W-1:0] HOURS_BASE  = 8'h01;
    localparam logic [BYTE_W-1:0] HOURS_RESET = 8'h12;

    localparam logic [BYTE_W-1:0] MASK_TENTHS = 8'h0F;
    localparam logic [BYTE_W-1:0] MASK_SIXTY  = 8'h7F;
    localparam logic [BYTE_W-1:0] MASK_HOURS  = 8'h1F;

    // One BCD increment: wraps from top to base with a carry out.
    function automatic bcd_roll_t bcd_roll(
        input logic [BYTE_W-1:0] v,
        input logic [BYTE_W-1:0] top,
        input logic [BYTE_W-1:0] base
    );
        bcd_roll_t r;
        if (v == top) begin
            r.carry = 1'b1;
            r.value = base;
        end else if (v[3:0] == 4'd9) begin
            r.carry = 1'b0;
            r.value = {v[7:4] + 4'd1, 4'd0};
        end else begin
            r.carry = 1'b0;
            r.value = v + 8'd1;
        end
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] field_mask(input logic [ADDR_W-1:0] a);
        case (a)
            FLD_TENTHS: return MASK_TENTHS;
            FLD_SECS,
            FLD_MINS:   return MASK_SIXTY;
            FLD_HOURS:  return MASK_HOURS;
            default:    return '0;
        endcase
    endfunction

endpackage

// File: rtl/tod_tick_sync.sv
module tod_tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise
);
    // stages 0..STAGES-1 synchronise, stage STAGES holds the previous sample
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= pin;
    end

    for (genvar i = 1; i <= STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[i] <= 1'b0;
            else     chain[i] <= chain[i-1];
        end
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
    parameter int TICKS_60 = 6,
    parameter int TICKS_50 = 5,
    localparam int MAX_T  = (TICKS_60 > TICKS_50) ? TICKS_60 : TICKS_50,
    localparam int CNT_W  = $clog2(MAX_T + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             rate50,
    input  logic             rise,
    output logic             step,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] LIM60 = CNT_W'(TICKS_60 - 1);
    localparam logic [CNT_W-1:0] LIM50 = CNT_W'(TICKS_50 - 1);

    logic [CNT_W-1:0] limit;
    logic             at_limit;

    assign limit    = rate50 ? LIM50 : LIM60;
    assign at_limit = (count >= limit);
    assign step     = rise & run & at_limit;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            count <= '0;
        end else if (rise) begin
            count <= at_limit ? '0 : count + CNT_W'(1);
        end
    end
endmodule

// File: rtl/tod_time_chain.sv
module tod_time_chain
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output tod_time_t         now
);
    tod_time_t nxt;
    bcd_roll_t r_t, r_s, r_m, r_h;
    logic      time_wr;
    logic [BYTE_W-1:0] wdat;

    assign time_wr = wr_en && (wr_addr <= FLD_HOURS);
    assign wdat    = wr_data & field_mask(wr_addr);

    always_comb begin
        r_t = bcd_roll(now.tenths, TENTHS_TOP, 8'h00);
        r_s = bcd_roll(now.secs,   SIXTY_TOP,  8'h00);
        r_m = bcd_roll(now.mins,   SIXTY_TOP,  8'h00);
        r_h = bcd_roll(now.hours,  HOURS_TOP,  HOURS_BASE);
        nxt = now;
        if (time_wr) begin
            case (wr_addr)
                FLD_TENTHS: nxt.tenths = wdat;
                FLD_SECS:   nxt.secs   = wdat;
                FLD_MINS:   nxt.mins   = wdat;
                default:    nxt.hours  = wdat;
            endcase
        end else if (step) begin
            nxt.tenths = r_t.value;
            if (r_t.carry) begin
                nxt.secs = r_s.value;
                if (r_s.carry) begin
                    nxt.mins = r_m.value;
                    if (r_m.carry) nxt.hours = r_h.value;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            now.tenths <= '0;
            now.secs   <= '0;
            now.mins   <= '0;
            now.hours  <= HOURS_RESET;
        end else begin
            now <= nxt;
        end
    end
endmodule

// File: rtl/tod_clock.sv
module tod_clock
    import tod_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TICKS_60    = 6,
    parameter int TICKS_50    = 5,
    localparam int MAX_T  = (TICKS_60 > TICKS_50) ? TICKS_60 : TICKS_50,
    localparam int CNT_W  = $clog2(MAX_T + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data
);
    logic             tick_rise;
    logic             step;
    logic [CNT_W-1:0] pre_cnt;
    logic             running;
    logic             rate50;
    tod_time_t        time_q;

    tod_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .pin (tick_in),
        .rise(tick_rise)
    );

    tod_prescaler #(.TICKS_60(TICKS_60), .TICKS_50(TICKS_50)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .run   (running),
        .rate50(rate50),
        .rise  (tick_rise),
        .step  (step),
        .count (pre_cnt)
    );

    tod_time_chain u_chain (
        .clk    (clk),
        .rst    (rst),
        .step   (step),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .now    (time_q)
    );

    // start on tenths write, stop on hours write, rate bit on control write
    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            rate50  <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == FLD_TENTHS) running <= 1'b1;
            if (wr_addr == FLD_HOURS)  running <= 1'b0;
            if (wr_addr == FLD_CTRL)   rate50  <= wr_data[RATE_BIT];
        end
    end

    always_comb begin
        case (rd_addr)
            FLD_TENTHS: rd_data = time_q.tenths;
            FLD_SECS:   rd_data = time_q.secs;
            FLD_MINS:   rd_data = time_q.mins;
            FLD_HOURS:  rd_data = time_q.hours;
            FLD_CTRL:   rd_data = {rate50, {(BYTE_W-1){1'b0}}};
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk
    import tod_pkg::*;
#(
    parameter int CNT_W    = 3,
    parameter int TICKS_60 = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              step,
    input logic              running,
    input logic              rate50,
    input logic [CNT_W-1:0]  cnt,
    input tod_time_t         now
);
    a_r1_reset_halted: assert property (@(posedge clk)
        rst |=> (!running && !rate50));

    a_r4_start_on_tenths: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == FLD_TENTHS) |=> running);

    a_r5_halt_on_hours: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == FLD_HOURS) |=> !running);

    a_r3_time_only_on_step: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !step) |=> $stable(now));

    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(TICKS_60 - 1));

    a_r7_tenths_wrap: assert property (@(posedge clk) disable iff (rst)
        (step && !wr_en && now.tenths == 8'h09) |=> (now.tenths == 8'h00));

    a_r8_hours_wrap: assert property (@(posedge clk) disable iff (rst)
        (step && !wr_en && now == {8'h12, 8'h59, 8'h59, 8'h09})
        |=> (now.hours == 8'h01 && now.mins == 8'h00));
endmodule

bind tod_clock tod_clock_chk #(.CNT_W(CNT_W), .TICKS_60(TICKS_60)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .step   (step),
    .running(running),
    .rate50 (rate50),
    .cnt    (pre_cnt),
    .now    (time_q)
);

// File: tb/tod_clock_bench.sv
`timescale 1ns/100ps
module tod_clock_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tod_clock u_tod_clock (
        .clk(clk), .rst(rst), .tick_in(tick_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // ---------------- behavioural reference (decimal integers) ----------------
    int m_t, m_s, m_m, m_h, m_cnt;
    bit m_run, m_rate, q1, q2, q3;

    function automatic int from_bcd(input logic [7:0] b);
        return (b >> 4) * 10 + (b & 8'h0F);
    endfunction
    function automatic logic [7:0] to_bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_t = 0; m_s = 0; m_m = 0; m_h = 12; m_cnt = 0;
            m_run = 0; m_rate = 0; q1 = 0; q2 = 0; q3 = 0;
        end else begin
            int lim;
            bit edge_seen, stp, twr;
            lim = m_rate ? 5 : 6;
            edge_seen = q2 && !q3;
            stp = edge_seen && m_run && (m_cnt >= lim - 1);
            twr = wr_en && (wr_addr < 3'd4);
            if (!m_run) m_cnt = 0;
            else if (edge_seen) m_cnt = stp ? 0 : m_cnt + 1;
            if (twr) begin
                case (wr_addr)
                    3'd0: m_t = from_bcd(wr_data & 8'h0F);
                    3'd1: m_s = from_bcd(wr_data & 8'h7F);
                    3'd2: m_m = from_bcd(wr_data & 8'h7F);
                    default: m_h = from_bcd(wr_data & 8'h1F);
                endcase
            end else if (stp) begin
                m_t = m_t + 1;
                if (m_t == 10) begin
                    m_t = 0; m_s = m_s + 1;
                    if (m_s == 60) begin
                        m_s = 0; m_m = m_m + 1;
                        if (m_m == 60) begin
                            m_m = 0;
                            m_h = (m_h == 12) ? 1 : m_h + 1;
                        end
                    end
                end
            end
            if (wr_en && wr_addr == 3'd0) m_run = 1;
            if (wr_en && wr_addr == 3'd3) m_run = 0;
            if (wr_en && wr_addr == 3'd4) m_rate = wr_data[7];
            q3 = q2; q2 = q1; q1 = tick_in;
        end
    end

    function automatic logic [7:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return to_bcd(m_t);
            3'd1: return to_bcd(m_s);
            3'd2: return to_bcd(m_m);
            3'd3: return to_bcd(m_h);
            3'd4: return {m_rate, 7'b0};
            default: return 8'h00;
        endcase
    endfunction

    // compare every clock, away from the active edge (R10 read map, all fields)
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (rd_data !== model_read(rd_addr)) begin
                failures++;
                $display("FAIL R10 model compare addr=%0d actual=%h expected=%h",
                         rd_addr, rd_data, model_read(rd_addr));
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk); #1;
        rd_addr = a;
        @(negedge clk);
        v = rd_data;
    endtask

    task automatic pulses(input int n, input int hi, input int lo);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1; tick_in = 1'b1;
            repeat (hi) @(negedge clk);
            #1; tick_in = 1'b0;
            repeat (lo) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic load(input logic [7:0] h, input logic [7:0] m,
                        input logic [7:0] s, input logic [7:0] t);
        do_write(3'd3, h); do_write(3'd2, m); do_write(3'd1, s); do_write(3'd0, t);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;

        // R1 reset values
        do_read(3'd0, v); check("R1 tenths", v, 8'h00);
        do_read(3'd1, v); check("R1 secs", v, 8'h00);
        do_read(3'd2, v); check("R1 mins", v, 8'h00);
        do_read(3'd3, v); check("R1 hours", v, 8'h12);
        do_read(3'd4, v); check("R1 ctrl", v, 8'h00);
        pulses(8, 4, 4);
        do_read(3'd0, v); check("R1 halted after reset", v, 8'h00);

        // R3 60 Hz mode
        do_write(3'd0, 8'h00);
        pulses(12, 4, 4);
        do_read(3'd0, v); check("R3 twelve edges at 60Hz", v, 8'h02);

        // R5 halt, R4 restart with empty prescaler
        pulses(4, 4, 4);
        do_write(3'd3, 8'h12);
        pulses(10, 4, 4);
        do_read(3'd0, v); check("R5 halted ignores ticks", v, 8'h02);
        do_write(3'd0, 8'h05);
        pulses(4, 4, 4);
        do_read(3'd0, v); check("R4 prescaler emptied on restart", v, 8'h05);
        pulses(2, 4, 4);
        do_read(3'd0, v); check("R4 first step after six", v, 8'h06);

        // R6 50 Hz mode
        do_write(3'd4, 8'h80);
        do_read(3'd4, v); check("R10 ctrl readback", v, 8'h80);
        do_write(3'd3, 8'h12); do_write(3'd0, 8'h00);
        pulses(10, 4, 4);
        do_read(3'd0, v); check("R6 ten edges at 50Hz", v, 8'h02);
        pulses(5, 4, 4);
        do_read(3'd0, v); check("R6 five more edges", v, 8'h03);

        // R7 R8 full rollover
        load(8'h12, 8'h59, 8'h59, 8'h09);
        pulses(5, 4, 4);
        do_read(3'd0, v); check("R7 tenths wrap", v, 8'h00);
        do_read(3'd1, v); check("R7 secs wrap", v, 8'h00);
        do_read(3'd2, v); check("R7 mins wrap", v, 8'h00);
        do_read(3'd3, v); check("R8 hours 12 to 01", v, 8'h01);

        load(8'h09, 8'h59, 8'h59, 8'h09);
        pulses(5, 4, 4);
        do_read(3'd3, v); check("R8 hours 09 to 10", v, 8'h10);

        do_write(3'd1, 8'h09); do_write(3'd0, 8'h09);
        pulses(5, 4, 4);
        do_read(3'd1, v); check("R7 secs 09 to 10", v, 8'h10);

        // R9 write masking
        do_write(3'd1, 8'hD9);
        do_read(3'd1, v); check("R9 secs mask", v, 8'h59);
        do_write(3'd3, 8'hF1);
        do_read(3'd3, v); check("R9 hours mask", v, 8'h11);
        do_write(3'd0, 8'hF3);
        do_read(3'd0, v); check("R9 tenths mask", v, 8'h03);

        // R2 pulse shapes, back at 60 Hz
        do_write(3'd4, 8'h00);
        do_write(3'd3, 8'h01); do_write(3'd0, 8'h00);
        pulses(6, 1, 1);
        do_read(3'd0, v); check("R2 one-cycle pulses", v, 8'h01);
        pulses(6, 20, 3);
        do_read(3'd0, v); check("R2 stretched pulses", v, 8'h02);

        // R10 unused addresses
        do_read(3'd5, v); check("R10 addr5 zero", v, 8'h00);
        do_read(3'd7, v); check("R10 addr7 zero", v, 8'h00);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule